// File: doc/BRIEF.md
# Same-Address Busy Arbiter

This block sits in front of a memory with two independent ports, called left and right. Every clock cycle it compares the two ports' word addresses and active-low enables. When both ports are enabled and point at the same word, it pulls exactly one active-low busy line low. The busy line goes to the port whose request settled later, and that port's write strobe is suppressed. The port that was there first keeps full access. The suppressed write is dropped. It is never held back, queued or replayed.

Arrival order is judged at clock resolution. A port's request is "new" in a cycle if it was disabled in the previous cycle, or if its address differs from the one it presented then. A request that has held its enable and address since the previous cycle counts as older. When both requests are new in the same cycle, the left port wins. Busy is produced combinationally from the present inputs and a small registered history, so a collision blocks the write in the same cycle that it appears.

A build-time switch selects master or slave operation. A master decides the busy outcome itself. A slave drives both busy outputs high and only obeys two external active-low busy inputs. In either mode, a low external busy input also blocks that port's writes.

Top module: `addr_busy_arb`

## Requirements
- R1: When either enable is high (inactive) or the two addresses differ, both busy outputs are high.
- R2: In master mode, when both enables are low and the addresses are equal, exactly one busy output is low.
- R3: In master mode, on a collision the port whose request is newer gets busy low, while the older port's busy stays high. A request is newer if it was disabled or had a different address in the previous cycle.
- R4: The two busy outputs are never low in the same cycle.
- R5: A port's write-accept output is high only when that port is enabled (enable low), its write strobe is low, and its busy output is high. A write made while busy is low is lost.
- R6: In master mode, when both requests are new in the same cycle and collide, the left port wins and the right busy output goes low.
- R7: In master mode, while both requests hold their enables and addresses, the busy outputs do not change. When either request changes or ends, busy is re-evaluated in that same cycle: the loser's busy rises as soon as the winner leaves.
- R8: While reset is asserted (low), both busy outputs are high and both write-accept outputs are low. Reset also clears the arrival history.
- R9: In slave mode both busy outputs stay high. In both modes, a low external busy input blocks writes on its own port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| left_en_n | input | 1 | Left port enable, active low |
| left_wr_n | input | 1 | Left port write strobe, active low |
| left_addr | input | AW | Left port word address |
| left_busy_in_n | input | 1 | External busy for the left port, active low |
| right_en_n | input | 1 | Right port enable, active low |
| right_wr_n | input | 1 | Right port write strobe, active low |
| right_addr | input | AW | Right port word address |
| right_busy_in_n | input | 1 | External busy for the right port, active low |
| left_busy_n | output | 1 | Left busy, active low |
| right_busy_n | output | 1 | Right busy, active low |
| left_wr_ok | output | 1 | Left write accepted toward the array |
| right_wr_ok | output | 1 | Right write accepted toward the array |

## Verification
The bench targets these corner cases:

- **Same-cycle arrival.** A design without a tie-break would lower both busy lines or neither.
- **Address hop by the winning port onto the loser's word.** Here the former winner becomes the newer request and must lose. A design that keeps ownership sticky would block the wrong port.
- **Release when the winner leaves.** The loser must be freed in that same cycle. A late release shows up as a busy low with no match present.
- **Writes during busy.** Any leak shows up as a write-accept high next to a low busy.
- **Slave instance with random external busy levels.** This checks that the slave never drives busy and obeys the external inputs.

// File: rtl/addr_busy_arb.sv
module addr_busy_arb #(
  parameter int AW        = 10,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          left_en_n,
  input  logic          left_wr_n,
  input  logic [AW-1:0] left_addr,
  input  logic          left_busy_in_n,
  input  logic          right_en_n,
  input  logic          right_wr_n,
  input  logic [AW-1:0] right_addr,
  input  logic          right_busy_in_n,
  output logic          left_busy_n,
  output logic          right_busy_n,
  output logic          left_wr_ok,
  output logic          right_wr_ok
);
  typedef enum logic [1:0] {OWN_NONE, OWN_LEFT, OWN_RIGHT} owner_e;

  owner_e        owner_q, owner_d;
  logic          l_act_q, r_act_q;
  logic [AW-1:0] l_addr_q, r_addr_q;

  wire l_act = ~left_en_n;
  wire r_act = ~right_en_n;
  wire hit   = l_act & r_act & (left_addr == right_addr);
  wire l_new = l_act & (~l_act_q | (left_addr  != l_addr_q));
  wire r_new = r_act & (~r_act_q | (right_addr != r_addr_q));

  always_comb begin
    if (!hit)                   owner_d = OWN_NONE;
    else if (l_new && r_new)    owner_d = OWN_LEFT;
    else if (l_new)             owner_d = OWN_RIGHT;
    else if (r_new)             owner_d = OWN_LEFT;
    else if (owner_q == OWN_NONE) owner_d = OWN_LEFT;
    else                        owner_d = owner_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      l_act_q  <= 1'b0;
      r_act_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      owner_q  <= owner_d;
      l_act_q  <= l_act;
      r_act_q  <= r_act;
      l_addr_q <= left_addr;
      r_addr_q <= right_addr;
    end
  end

  wire l_lose = IS_MASTER & rst_n & (owner_d == OWN_RIGHT);
  wire r_lose = IS_MASTER & rst_n & (owner_d == OWN_LEFT);

  assign left_busy_n  = ~l_lose;
  assign right_busy_n = ~r_lose;

  assign left_wr_ok  = rst_n & l_act & ~left_wr_n  & ~l_lose & left_busy_in_n;
  assign right_wr_ok = rst_n & r_act & ~right_wr_n & ~r_lose & right_busy_in_n;
endmodule

module addr_busy_arb_chk #(
  parameter int AW        = 10,
  parameter bit IS_MASTER = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          left_en_n,
  input logic          right_en_n,
  input logic [AW-1:0] left_addr,
  input logic [AW-1:0] right_addr,
  input logic          left_busy_in_n,
  input logic          right_busy_in_n,
  input logic          left_busy_n,
  input logic          right_busy_n,
  input logic          left_wr_ok,
  input logic          right_wr_ok
);
  wire hit = ~left_en_n & ~right_en_n & (left_addr == right_addr);

  assert_both_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (left_busy_n && right_busy_n));

  assert_never_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!left_busy_n && !right_busy_n));

  assert_left_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !left_busy_n |-> !left_wr_ok);

  assert_right_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !right_busy_n |-> !right_wr_ok);

  assert_ext_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_busy_in_n |-> !left_wr_ok) and (!right_busy_in_n |-> !right_wr_ok));

  always @(posedge clk)
    if (!rst_n) assert_reset_high_R8: assert (left_busy_n && right_busy_n && !left_wr_ok && !right_wr_ok);

  if (IS_MASTER) begin : g_master
    assert_one_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($countones({!left_busy_n, !right_busy_n}) == 1));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(hit) && $past(rst_n) && $stable(left_addr) && $stable(right_addr))
        |-> ($stable(left_busy_n) && $stable(right_busy_n)));
  end else begin : g_slave
    assert_slave_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      left_busy_n && right_busy_n);
  end
endmodule

bind addr_busy_arb addr_busy_arb_chk #(.AW(AW), .IS_MASTER(IS_MASTER)) u_chk (.*);

// File: tb/addr_busy_arb_test.sv
module addr_busy_arb_test;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic l_en_n = 1'b1, r_en_n = 1'b1, l_wr_n = 1'b1, r_wr_n = 1'b1;
  logic [AW-1:0] la = '0, ra = '0;
  logic s_lbin = 1'b1, s_rbin = 1'b1;
  logic m_lb, m_rb, m_lw, m_rw, s_lb, s_rb, s_lw, s_rw;

  addr_busy_arb #(.AW(AW), .IS_MASTER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .left_en_n(l_en_n), .left_wr_n(l_wr_n), .left_addr(la), .left_busy_in_n(1'b1),
    .right_en_n(r_en_n), .right_wr_n(r_wr_n), .right_addr(ra), .right_busy_in_n(1'b1),
    .left_busy_n(m_lb), .right_busy_n(m_rb), .left_wr_ok(m_lw), .right_wr_ok(m_rw));

  addr_busy_arb #(.AW(AW), .IS_MASTER(1'b0)) uut_slave (
    .clk(clk), .rst_n(rst_n),
    .left_en_n(l_en_n), .left_wr_n(l_wr_n), .left_addr(la), .left_busy_in_n(s_lbin),
    .right_en_n(r_en_n), .right_wr_n(r_wr_n), .right_addr(ra), .right_busy_in_n(s_rbin),
    .left_busy_n(s_lb), .right_busy_n(s_rb), .left_wr_ok(s_lw), .right_wr_ok(s_rw));

  int checks = 0, fails = 0;
  bit done = 0;

  // history kept by the bench: 0 = none, 1 = left owns, 2 = right owns
  bit pl_act = 0, pr_act = 0;
  logic [AW-1:0] pla = '0, pra = '0;
  int own = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_owner(bit lact, bit ract, logic [AW-1:0] a, logic [AW-1:0] b);
    bit hit, ln, rn;
    hit = lact && ract && (a == b);
    ln  = lact && (!pl_act || a != pla);
    rn  = ract && (!pr_act || b != pra);
    if (!hit) return 0;
    if (ln && rn) return 1;
    if (ln) return 2;
    if (rn) return 1;
    return (own == 0) ? 1 : own;
  endfunction

  // called just after a falling edge; checks, advances the model, waits for the next falling edge
  task automatic cyc();
    bit lact, ract, hit, ln, rn, elb, erb, elw, erw;
    int nxt;
    string tag;
    #1;
    lact = !l_en_n; ract = !r_en_n;
    hit  = lact && ract && (la == ra);
    ln   = lact && (!pl_act || la != pla);
    rn   = ract && (!pr_act || ra != pra);
    nxt  = rst_n ? next_owner(lact, ract, la, ra) : 0;
    elb  = !(rst_n && nxt == 2);
    erb  = !(rst_n && nxt == 1);
    elw  = rst_n && lact && !l_wr_n && elb;
    erw  = rst_n && ract && !r_wr_n && erb;
    if (!rst_n) tag = "R8";
    else if (!hit) tag = "R1";
    else if (ln && rn) tag = "R6";
    else if (ln || rn) tag = "R3";
    else tag = "R7";
    chk(m_lb == elb, tag, m_lb, elb);
    chk(m_rb == erb, tag, m_rb, erb);
    chk(m_lb || m_rb, "R4", {m_lb, m_rb}, 3);
    if (rst_n && hit) chk((!m_lb) ^ (!m_rb), "R2", {m_lb, m_rb}, 1);
    chk(m_lw == elw, "R5", m_lw, elw);
    chk(m_rw == erw, "R5", m_rw, erw);
    chk(s_lb && s_rb, "R9", {s_lb, s_rb}, 3);
    chk(s_lw == (rst_n && lact && !l_wr_n && s_lbin), "R9", s_lw, rst_n && lact && !l_wr_n && s_lbin);
    chk(s_rw == (rst_n && ract && !r_wr_n && s_rbin), "R9", s_rw, rst_n && ract && !r_wr_n && s_rbin);
    if (rst_n) begin
      own = nxt; pl_act = lact; pr_act = ract; pla = la; pra = ra;
    end else begin
      own = 0; pl_act = 0; pr_act = 0; pla = '0; pra = '0;
    end
    @(negedge clk);
  endtask

  task automatic drive(bit le, logic [AW-1:0] a, bit lw, bit re, logic [AW-1:0] b, bit rw);
    l_en_n = !le; la = a; l_wr_n = !lw;
    r_en_n = !re; ra = b; r_wr_n = !rw;
    cyc();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R8: collision presented during reset
    drive(1, 10'h3FF, 1, 1, 10'h3FF, 1);
    drive(1, 10'h3FF, 1, 1, 10'h3FF, 1);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    // R3: left first, right arrives later -> right busy, right write lost
    drive(1, 10'h3FE, 1, 0, 0, 0);
    drive(1, 10'h3FE, 1, 1, 10'h3FE, 1);
    drive(1, 10'h3FE, 1, 1, 10'h3FE, 1);   // R7 hold
    // R7: winner leaves, loser freed same cycle
    drive(0, 10'h3FE, 0, 1, 10'h3FE, 1);
    // R3: right now older, left returns -> left busy
    drive(1, 10'h3FE, 1, 1, 10'h3FE, 1);
    // R3: right hops off then back while left stays -> right becomes newer
    drive(1, 10'h3FE, 1, 1, 10'h001, 1);
    drive(1, 10'h3FE, 1, 1, 10'h3FE, 1);
    drive(0, 0, 0, 0, 0, 0);
    // R6: same-cycle arrival
    drive(1, 10'h155, 1, 1, 10'h155, 1);
    drive(1, 10'h155, 0, 1, 10'h155, 1);
    // R1: different addresses, both write
    drive(1, 10'h155, 1, 1, 10'h156, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pick [4];
      pick[0] = 10'h000; pick[1] = 10'h001; pick[2] = 10'h3FE; pick[3] = 10'h3FF;
      if ($urandom_range(0, 9) < 3) begin
        l_en_n = ($urandom_range(0, 3) == 0);
        la = pick[$urandom_range(0, 3)];
      end
      if ($urandom_range(0, 9) < 3) begin
        r_en_n = ($urandom_range(0, 3) == 0);
        ra = pick[$urandom_range(0, 3)];
      end
      l_wr_n = $urandom_range(0, 1);
      r_wr_n = $urandom_range(0, 1);
      s_lbin = ($urandom_range(0, 3) != 0);
      s_rbin = ($urandom_range(0, 3) != 0);
      if (i == 1500) rst_n = 1'b0;
      if (i == 1503) rst_n = 1'b1;
      cyc();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule